// File: doc/BRIEF.md
# Packed Trace Word Unpacker

This block sits behind a trace capture buffer readout. It takes 32-bit words, each of which holds one, two or three packed trace entries, and sends the entries out one at a time. Every output entry has a 3-bit pipeline status, a packet field of up to 16 bits, a sync flag and a trigger flag. A width selector, sampled with each word, tells the block how the word is packed: a narrow 4-bit trace port yields three entries per word, an 8-bit port yields two, and a 16-bit port yields one.

Both sides use a valid/ready handshake. The block holds one word at a time. It takes the next word only when it is empty or when the final entry of the current word leaves in the same cycle, so back-to-back words flow without a bubble. When an extracted status carries the trigger marker, the real status is in the low three bits of that entry's packet field. The block puts that value on the status output and raises the trigger flag.

Top module: `trace_word_unpacker`

## Requirements
- R1: With `port_mode` = 2'b00 a word gives three entries. Entry 0 takes status from word[2:0], packet from [6:3] and sync from [7]. Entry 1 takes status from word[8] (zero-extended), packet from [14:11] and sync from [15]. Entry 2 takes status from word[16] (zero-extended), packet from [22:19] and sync from [23]. Packets are zero-extended to 16 bits.
- R2: With `port_mode` = 2'b01 a word gives two entries. Entry 0 takes status from [2:0], packet from [10:3] and sync from [11]. Entry 1 takes status from [14:12], packet from [22:15] and sync from [23].
- R3: With `port_mode` = 2'b10 or 2'b11 a word gives one entry: status from [2:0], packet from [18:3] and sync from [19].
- R4: Entries of a word leave in order from the lowest bit field to the highest.
- R5: When an extracted status equals the parameter TRIG_CODE (default 3'b110), `out_status` shows packet bits [2:0] and `out_trigger` is 1. Otherwise `out_trigger` is 0 and `out_status` is the extracted status.
- R6: While `out_valid` is 1 and `out_ready` is 0, `out_valid` stays 1 and every output field keeps its value.
- R7: `in_ready` is 1 exactly when the block is empty, or when it is presenting the last entry of its word and `out_ready` is 1.
- R8: `port_mode` is sampled only when a word is accepted. Changing it while a word is being unpacked has no effect on that word's entries.
- R9: After reset `out_valid` is 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| port_mode | input | 2 | Packing width: 00 = 4-bit, 01 = 8-bit, 1x = 16-bit |
| in_valid | input | 1 | Input word valid |
| in_ready | output | 1 | Block can take a word |
| in_word | input | 32 | Packed trace word |
| out_valid | output | 1 | Entry valid |
| out_ready | input | 1 | Consumer takes the entry |
| out_status | output | 3 | Pipeline status, with the trigger substitution applied |
| out_packet | output | 16 | Packet field, zero-extended |
| out_sync | output | 1 | Sync flag |
| out_trigger | output | 1 | Trigger marker was seen on this entry |

## Verification
The assertions assume that the consumer obeys the handshake. They also assume that the width selector is meaningful only at the cycle in which a word is accepted, so the selector is free to change at any other time. To exercise this, the stimulus flips the selector right after each acceptance. It also lowers the output ready signal in irregular patterns, which keeps words waiting while a partly emitted word is stalled. Input words come from a shift-register sequence. Directed words plant the trigger code in every status slot that is wide enough to hold it.

// File: rtl/trace_word_unpacker.sv
`timescale 1ns/1ps
module trace_word_unpacker #(
  parameter logic [2:0] TRIG_CODE = 3'b110,
  parameter int WORD_W = 32,
  parameter int PKT_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        port_mode,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [WORD_W-1:0] in_word,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [2:0]        out_status,
  output logic [PKT_W-1:0]  out_packet,
  output logic              out_sync,
  output logic              out_trigger
);

  logic [WORD_W-1:0] word_q;
  logic [1:0]        mode_q;
  logic [1:0]        idx_q;
  logic              full_q;
  logic [1:0]        n_ent;
  logic              last;
  logic              take_in, take_out;
  logic [2:0]        raw_st;
  logic [PKT_W-1:0]  raw_pk;
  logic              raw_sy;

  assign n_ent    = (mode_q == 2'b00) ? 2'd3 : (mode_q == 2'b01) ? 2'd2 : 2'd1;
  assign last     = (idx_q == n_ent - 2'd1);
  assign out_valid = full_q;
  assign in_ready = !full_q || (out_ready && last);
  assign take_in  = in_valid && in_ready;
  assign take_out = full_q && out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      full_q <= 1'b0;
      idx_q  <= '0;
      mode_q <= '0;
      word_q <= '0;
    end else if (take_in) begin
      full_q <= 1'b1;
      idx_q  <= '0;
      mode_q <= port_mode;
      word_q <= in_word;
    end else if (take_out) begin
      if (last) full_q <= 1'b0;
      else      idx_q  <= idx_q + 2'd1;
    end
  end

  always_comb begin
    raw_st = '0;
    raw_pk = '0;
    raw_sy = 1'b0;
    case (mode_q)
      2'b00: begin
        case (idx_q)
          2'd0: begin
            raw_st = word_q[2:0];
            raw_pk[3:0] = word_q[6:3];
            raw_sy = word_q[7];
          end
          2'd1: begin
            raw_st[0] = word_q[8];
            raw_pk[3:0] = word_q[14:11];
            raw_sy = word_q[15];
          end
          default: begin
            raw_st[0] = word_q[16];
            raw_pk[3:0] = word_q[22:19];
            raw_sy = word_q[23];
          end
        endcase
      end
      2'b01: begin
        if (idx_q == 2'd0) begin
          raw_st = word_q[2:0];
          raw_pk[7:0] = word_q[10:3];
          raw_sy = word_q[11];
        end else begin
          raw_st = word_q[14:12];
          raw_pk[7:0] = word_q[22:15];
          raw_sy = word_q[23];
        end
      end
      default: begin
        raw_st = word_q[2:0];
        raw_pk = word_q[18:3];
        raw_sy = word_q[19];
      end
    endcase
  end

  assign out_trigger = (raw_st == TRIG_CODE);
  assign out_status  = out_trigger ? raw_pk[2:0] : raw_st;
  assign out_packet  = raw_pk;
  assign out_sync    = raw_sy;

  a_r6_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_status) && $stable(out_packet)
                                   && $stable(out_sync) && $stable(out_trigger)));

  a_r4_index_steps: assert property (@(posedge clk) disable iff (!rst_n)
    (take_out && !last && !in_valid) |=> (full_q && idx_q == $past(idx_q) + 2'd1));

  a_r8_mode_held: assert property (@(posedge clk) disable iff (!rst_n)
    (full_q && !take_in) |=> $stable(mode_q));

  a_r7_no_early_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);

  a_r3_index_bound: assert property (@(posedge clk) disable iff (!rst_n)
    full_q |-> (idx_q < n_ent));

  a_r9_empty_after_reset: assert property (@(posedge clk)
    $past(!rst_n) |-> !out_valid);

endmodule

// File: tb/trace_word_unpacker_tb_top.sv
`timescale 1ns/1ps
module trace_word_unpacker_tb_top;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [1:0]  port_mode = 2'b00;
  logic        in_valid = 0;
  logic        in_ready;
  logic [31:0] in_word = '0;
  logic        out_valid;
  logic        out_ready = 0;
  logic [2:0]  out_status;
  logic [15:0] out_packet;
  logic        out_sync;
  logic        out_trigger;

  int checks = 0;
  int fails = 0;
  bit done = 0;
  int cyc = 0;
  bit ready_all = 0;

  logic [21:0] exp_q[$];
  string       tag_q[$];

  always #2.5 clk = ~clk;

  trace_word_unpacker dut_i (
    .clk(clk), .rst_n(rst_n), .port_mode(port_mode),
    .in_valid(in_valid), .in_ready(in_ready), .in_word(in_word),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_status(out_status), .out_packet(out_packet),
    .out_sync(out_sync), .out_trigger(out_trigger)
  );

  function automatic logic [21:0] expect_entry(input logic [31:0] w, input logic [1:0] m, input int k);
    logic [2:0] st; logic [15:0] pk; logic sy; logic tr;
    st = '0; pk = '0; sy = 0;
    if (m == 2'b00) begin
      if (k == 0)      begin st = w[2:0]; pk[3:0] = w[6:3]; sy = w[7]; end
      else if (k == 1) begin st = {2'b00, w[8]}; pk[3:0] = w[14:11]; sy = w[15]; end
      else             begin st = {2'b00, w[16]}; pk[3:0] = w[22:19]; sy = w[23]; end
    end else if (m == 2'b01) begin
      if (k == 0) begin st = w[2:0]; pk[7:0] = w[10:3]; sy = w[11]; end
      else        begin st = w[14:12]; pk[7:0] = w[22:15]; sy = w[23]; end
    end else begin
      st = w[2:0]; pk = w[18:3]; sy = w[19];
    end
    tr = (st == 3'b110);
    if (tr) st = pk[2:0];
    return {tr, sy, pk, st};
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // driver: offers a word, pushes expected entries on acceptance, then disturbs the mode (R8)
  task automatic send(input logic [31:0] w, input logic [1:0] m, input int gap);
    int n;
    bit acc;
    repeat (gap) @(negedge clk);
    @(negedge clk);
    in_valid = 1; in_word = w; port_mode = m;
    n = (m == 2'b00) ? 3 : (m == 2'b01) ? 2 : 1;
    acc = 0;
    while (!acc) begin
      #2;
      if (in_ready) begin
        for (int k = 0; k < n; k++) begin
          logic [21:0] e;
          e = expect_entry(w, m, k);
          exp_q.push_back(e);
          tag_q.push_back(e[21] ? "R5" : (m == 2'b00) ? "R1 R4" : (m == 2'b01) ? "R2 R4" : "R3");
        end
        @(posedge clk);
        #0.5;
        in_valid = 0;
        port_mode = ~m;
        in_word = ~w;
        acc = 1;
      end else begin
        @(negedge clk);
      end
    end
  endtask

  // monitor: sets ready at the falling edge, compares 1 ns later
  logic [21:0] held;
  bit          was_stalled = 0;
  always @(negedge clk) begin
    cyc++;
    out_ready = ready_all ? 1'b1 : ((cyc % 5) != 1 && (cyc % 7) != 3);
    #1;
    if (rst_n && !done) begin
      bit exp_rdy;
      exp_rdy = (exp_q.size() == 0) || (exp_q.size() == 1 && out_ready);
      check(in_ready == exp_rdy, "R7", {31'b0, in_ready}, {31'b0, exp_rdy});
      if (was_stalled)
        check(out_valid && {out_trigger, out_sync, out_packet, out_status} == held, "R6",
              {9'b0, out_valid, out_trigger, out_sync, out_packet, out_status}, {10'b0, held});
      check(out_valid == (exp_q.size() != 0), "R4 valid", {31'b0, out_valid}, {31'b0, exp_q.size() != 0});
      was_stalled = out_valid && !out_ready;
      held = {out_trigger, out_sync, out_packet, out_status};
      if (out_valid && out_ready && exp_q.size() != 0) begin
        logic [21:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check({out_trigger, out_sync, out_packet, out_status} == e, t,
              {10'b0, out_trigger, out_sync, out_packet, out_status}, {10'b0, e});
      end
    end
  end

  initial begin
    logic [31:0] lfsr;
    repeat (3) @(negedge clk);
    #1;
    check(out_valid == 0, "R9", {31'b0, out_valid}, 0);
    check(in_ready == 1, "R9", {31'b0, in_ready}, 1);
    @(negedge clk);
    rst_n = 1;
    #1;
    check(out_valid == 0 && in_ready == 1, "R9", {30'b0, out_valid, in_ready}, 1);
    // directed: trigger in each wide status slot, narrow slots and sync bits
    send(32'h0088_8036, 2'b00, 0);
    send(32'h0081_0187, 2'b00, 0);
    send(32'h00FF_FFFF, 2'b00, 0);
    send(32'h00E6_60AE, 2'b01, 1);
    send(32'h0080_6A56, 2'b01, 0);
    send(32'h000F_FFFE, 2'b10, 0);
    send(32'h0008_0000, 2'b10, 0);
    send(32'h0004_5676, 2'b11, 2);
    send(32'h0000_0000, 2'b00, 0);
    lfsr = 32'hACE1_2468;
    for (int i = 0; i < 300; i++) begin
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      if (i == 150) ready_all = 1;
      if (i == 220) ready_all = 0;
      send(lfsr, lfsr[25:24], (lfsr[29:28] == 2'b00) ? 1 : 0);
    end
    repeat (20) @(negedge clk);
    #1.5;
    check(exp_q.size() == 0, "R4 drained", exp_q.size(), 0);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule